// File: doc/BRIEF.md
# PIPE Transmit Width Adapter

This block sits between a MAC transmit stream and a SerDes that takes one 64-bit word of eight symbols per word clock. Each symbol is one byte. A control flag and a compliance flag travel with every byte. The control flag marks a control symbol. The compliance flag marks a compliance-pattern symbol that has to leave with negative disparity. In full-width mode the MAC hands over all eight symbols on every parallel clock cycle and the block registers them unchanged. In half-width mode the MAC runs its parallel clock at twice the SerDes word rate and sends four symbols per cycle. The block packs each pair of MAC words into one SerDes word and keeps every flag beside its own byte.

The doubled clock is modelled as the block's single clock. A phase toggle acts as the clock enable of the slower SerDes word, and `ser_stb` marks each cycle in which a newly assembled word is on the outputs. The width strap is sampled only while reset is asserted and is held until the next reset.

Top module: `pipe_tx_width_adapter`

## Requirements
- R1: While `rst_n` is low, `ser_data`, `ser_datak` and `ser_compl` read zero and `ser_stb` is low after the first clock edge.
- R2: In full-width mode, the symbols, control flags and compliance flags presented at a clock edge appear on the outputs right after that edge, and `ser_stb` is high on every cycle after reset.
- R3: In half-width mode, the first MAC word of a pair (bits 31:0) becomes output bytes 0 to 3 (bits 31:0), and the second becomes bytes 4 to 7 (bits 63:32). The packed word appears right after the clock edge that captured the second word.
- R4: Control flag bit i always leaves with the byte in output bits 8i+7:8i. In half-width mode, input flag bit j of the first word goes to output bit j, and input flag bit j of the second word goes to output bit j+4.
- R5: Compliance flag bits follow the same byte mapping as the control flags in both modes.
- R6: In half-width mode, `ser_stb` is high on alternate cycles only, and the outputs hold their value through the cycle in which it is low.
- R7: The phase toggle restarts at the first half after every reset. The first MAC word after reset always fills bytes 0 to 3, even when a pair was only half sent before the reset.
- R8: Width code 2'b01 selects half-width mode. Codes 2'b00, 2'b10 and 2'b11 all select full-width mode.
- R9: The width code is sampled only while `rst_n` is low. Changing it afterwards has no effect on packing until the next reset.
- R10: In half-width mode, the upper 32 data bits and the upper four bits of both flag inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel interface clock |
| rst_n | input | 1 | Synchronous active-low reset; the width strap is latched while it is low |
| width_code | input | 2 | Width strap: 2'b01 half width, any other value full width |
| mac_data | input | 64 | MAC transmit symbols, byte i in bits 8i+7:8i |
| mac_datak | input | 8 | Per-symbol control flags |
| mac_compl | input | 8 | Per-symbol compliance (negative disparity) flags |
| ser_data | output | 64 | Symbol word towards the SerDes |
| ser_datak | output | 8 | Control flags aligned with `ser_data` |
| ser_compl | output | 8 | Compliance flags aligned with `ser_data` |
| ser_stb | output | 1 | High for the cycle in which a new SerDes word is presented |

## Verification
The assertions assume the MAC delivers a new word on every clock cycle, with no idle gaps. Pairing in half-width mode is therefore fixed purely by the cycle count since reset. They also assume reset is held for at least one clock edge so that the strap is captured. The bench drives one word per cycle from reset release until its queue drains, and keeps reset low for several edges. It changes the strap only after reset release, and only to check that the change is ignored.

// File: rtl/pipe_txw_pkg.sv
// Shared types and helpers for the PIPE transmit width adapter.
// Assumes one symbol is a byte with two per-symbol flags.
package pipe_txw_pkg;

    localparam int SYM_W = 8;

    // Width strap encoding; only NARROW selects the 2:1 packing.
    typedef enum logic [1:0] {
        WCODE_NONE   = 2'b00,
        WCODE_NARROW = 2'b01,
        WCODE_WIDE   = 2'b10,
        WCODE_RSVD   = 2'b11
    } width_code_e;

    // One symbol with the flags that must stay attached to it.
    typedef struct packed {
        logic             compl;
        logic             ctrl;
        logic [SYM_W-1:0] octet;
    } sym_t;

    // Decode the strap; every code other than NARROW falls back to full width.
    function automatic logic code_is_narrow(input logic [1:0] code);
        return code == WCODE_NARROW;
    endfunction

endpackage

// File: rtl/txw_mode_latch.sv
// Latches the width strap while reset is asserted and holds it afterwards.
// Assumes reset is held low for at least one clock edge.
module txw_mode_latch
    import pipe_txw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] width_code,
    output logic       narrow_q
);

    // Capture the decoded strap during reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            narrow_q <= code_is_narrow(width_code);
        end
    end

    // R9: the selected width never moves while out of reset.
    assert_mode_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(narrow_q));

endmodule

// File: rtl/txw_phase_gen.sv
// Generates the half-select toggle that models the doubled parallel clock.
// Low phase = first MAC word of a pair, high phase = second word.
// Assumes the MAC presents a new word on every clock cycle.
module txw_phase_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic narrow,
    output logic phase_hi,
    output logic load_en
);

    // Toggle once per cycle in half-width mode; restart at the first half on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_hi <= 1'b0;
        end else if (narrow) begin
            phase_hi <= ~phase_hi;
        end else begin
            phase_hi <= 1'b0;
        end
    end

    // The output word loads every cycle in full width, on the second half otherwise.
    assign load_en = !narrow || phase_hi;

    // R8: full-width mode never leaves the first phase.
    assert_phase_idle_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !narrow |=> !phase_hi);

    // R6: half-width mode alternates halves on every cycle.
    assert_phase_alternates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |=> (phase_hi != $past(phase_hi)));

endmodule

// File: rtl/txw_lane_pack.sv
// Packs symbols into the SerDes word: pass-through in full width,
// first-half holding plus second-half fill in half width.
// Assumes phase_hi/load_en come from txw_phase_gen and a word arrives every cycle.
module txw_lane_pack
    import pipe_txw_pkg::*;
#(
    parameter int WIDE_SYMS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       narrow,
    input  logic                       phase_hi,
    input  logic                       load_en,
    input  sym_t [WIDE_SYMS-1:0]       in_syms,
    output sym_t [WIDE_SYMS-1:0]       out_syms,
    output logic                       out_stb
);

    localparam int NARROW_SYMS = WIDE_SYMS / 2;

    sym_t [WIDE_SYMS-1:0] nxt_syms;

    for (genvar i = 0; i < WIDE_SYMS; i++) begin : g_lane
        if (i < NARROW_SYMS) begin : g_low
            sym_t hold_q;

            // Keep the first-half symbol until the second half arrives.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_q <= '0;
                end else if (narrow && !phase_hi) begin
                    hold_q <= in_syms[i];
                end
            end

            assign nxt_syms[i] = narrow ? hold_q : in_syms[i];
        end else begin : g_high
            assign nxt_syms[i] = narrow ? in_syms[i-NARROW_SYMS] : in_syms[i];
        end
    end

    // Register the assembled word and flag its arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_syms <= '0;
            out_stb  <= 1'b0;
        end else begin
            out_stb <= load_en;
            if (load_en) begin
                out_syms <= nxt_syms;
            end
        end
    end

    // R2: full width is a one-cycle registered copy of the input symbols and flags.
    assert_wide_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !narrow |=> (out_syms == $past(in_syms)) && out_stb);

    // R3 (with R4, R5): a fresh half-width word is {second word, first word}.
    assert_narrow_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow && out_stb) |->
            (out_syms[NARROW_SYMS-1:0] == $past(in_syms[NARROW_SYMS-1:0], 2)) &&
            (out_syms[WIDE_SYMS-1:NARROW_SYMS] == $past(in_syms[NARROW_SYMS-1:0])));

    // R6: after a fresh half-width word the strobe drops and the word holds.
    assert_narrow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow && out_stb) |=> !out_stb && $stable(out_syms));

endmodule

// File: rtl/pipe_tx_width_adapter.sv
// PIPE transmit width adapter: 32- or 64-bit MAC stream to a 64-bit SerDes word,
// with per-symbol control and compliance flags carried alongside each byte.
// Assumes one MAC word per cycle and a width strap that is valid during reset.
module pipe_tx_width_adapter
    import pipe_txw_pkg::*;
#(
    parameter int WIDE_SYMS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    width_code,
    input  logic [WIDE_SYMS*SYM_W-1:0]    mac_data,
    input  logic [WIDE_SYMS-1:0]          mac_datak,
    input  logic [WIDE_SYMS-1:0]          mac_compl,
    output logic [WIDE_SYMS*SYM_W-1:0]    ser_data,
    output logic [WIDE_SYMS-1:0]          ser_datak,
    output logic [WIDE_SYMS-1:0]          ser_compl,
    output logic                          ser_stb
);

    logic narrow;
    logic phase_hi;
    logic load_en;
    sym_t [WIDE_SYMS-1:0] in_syms;
    sym_t [WIDE_SYMS-1:0] out_syms;

    // Bundle each byte with its flags on the way in, unbundle on the way out.
    for (genvar i = 0; i < WIDE_SYMS; i++) begin : g_sym
        assign in_syms[i].octet = mac_data[i*SYM_W +: SYM_W];
        assign in_syms[i].ctrl  = mac_datak[i];
        assign in_syms[i].compl = mac_compl[i];
        assign ser_data[i*SYM_W +: SYM_W] = out_syms[i].octet;
        assign ser_datak[i]               = out_syms[i].ctrl;
        assign ser_compl[i]               = out_syms[i].compl;
    end

    txw_mode_latch u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .width_code (width_code),
        .narrow_q   (narrow)
    );

    txw_phase_gen u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .narrow   (narrow),
        .phase_hi (phase_hi),
        .load_en  (load_en)
    );

    txw_lane_pack #(.WIDE_SYMS(WIDE_SYMS)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .narrow   (narrow),
        .phase_hi (phase_hi),
        .load_en  (load_en),
        .in_syms  (in_syms),
        .out_syms (out_syms),
        .out_stb  (ser_stb)
    );

endmodule

// File: tb/tb_pipe_tx_width_adapter.sv
`timescale 1ns/1ps
module tb_pipe_tx_width_adapter;

    typedef struct packed {
        logic [7:0]  c;
        logic [7:0]  k;
        logic [63:0] d;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  width_code = 2'b10;
    logic [63:0] mac_data = '0;
    logic [7:0]  mac_datak = '0;
    logic [7:0]  mac_compl = '0;
    logic [63:0] ser_data;
    logic [7:0]  ser_datak;
    logic [7:0]  ser_compl;
    logic        ser_stb;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    bit    mon_narrow = 0;
    bit    prev_stb = 0;
    string data_tag = "R2";
    exp_t  q[$];

    always #5 clk = ~clk;

    pipe_tx_width_adapter dut (
        .clk(clk), .rst_n(rst_n), .width_code(width_code),
        .mac_data(mac_data), .mac_datak(mac_datak), .mac_compl(mac_compl),
        .ser_data(ser_data), .ser_datak(ser_datak), .ser_compl(ser_compl),
        .ser_stb(ser_stb)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Byte-indexed symbol patterns with distinct flag patterns per word.
    function automatic logic [63:0] pat_data(input int w, input logic [7:0] base);
        logic [63:0] v;
        for (int j = 0; j < 8; j++) v[j*8 +: 8] = 8'(base + w*8 + j);
        return v;
    endfunction
    function automatic logic [7:0] pat_k(input int w, input logic [7:0] base);
        return 8'(w*37 + base);
    endfunction
    function automatic logic [7:0] pat_c(input int w, input logic [7:0] base);
        return 8'(w*91 + base*3) ^ 8'h5A;
    endfunction

    // Monitor: pops expected words as fresh output words appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_narrow && ser_stb)
                chk(!prev_stb, "R6", "strobe back-to-back", {63'd0, prev_stb}, 64'd0);
            if (ser_stb && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(ser_data == e.d, data_tag, "data", ser_data, e.d);
                chk(ser_datak == e.k, "R4", "control flags", {56'd0, ser_datak}, {56'd0, e.k});
                chk(ser_compl == e.c, "R5", "compliance flags", {56'd0, ser_compl}, {56'd0, e.c});
            end
            prev_stb = ser_stb;
        end else begin
            prev_stb = 1'b0;
        end
    end

    // Hold reset with the given strap, then check the reset state (R1).
    task automatic do_reset(input logic [1:0] code);
        rst_n = 1'b0;
        width_code = code;
        mac_data = 64'hA5A5_A5A5_A5A5_A5A5;
        mac_datak = 8'hFF;
        mac_compl = 8'hFF;
        repeat (3) @(negedge clk);
        chk(ser_data == 64'd0, "R1", "reset data", ser_data, 64'd0);
        chk(ser_datak == 8'd0 && ser_compl == 8'd0, "R1", "reset flags",
            {48'd0, ser_datak, ser_compl}, 64'd0);
        chk(ser_stb == 1'b0, "R1", "reset strobe", {63'd0, ser_stb}, 64'd0);
        q.delete();
        rst_n = 1'b1;
    endtask

    // Driver: one word per cycle, pushing the expected SerDes words.
    task automatic run(input bit narrow, input int n, input logic [7:0] base,
                       input string tag, input bit garbage, input bit flip);
        exp_t lo;
        lo = '0;
        data_tag = tag;
        mon_narrow = narrow;
        for (int w = 0; w < n; w++) begin
            logic [63:0] d;
            logic [7:0]  k;
            logic [7:0]  c;
            d = pat_data(w, base);
            k = pat_k(w, base);
            c = pat_c(w, base);
            if (flip && w == 3) width_code = narrow ? 2'b10 : 2'b01;
            if (narrow) begin
                mac_data  = garbage ? {~d[31:0] ^ 32'h1234_5678, d[31:0]} : d;
                mac_datak = garbage ? {4'hF, k[3:0]} : k;
                mac_compl = garbage ? {~c[3:0], c[3:0]} : c;
                if (w % 2 == 0) begin
                    lo.d = {32'd0, d[31:0]};
                    lo.k = {4'd0, k[3:0]};
                    lo.c = {4'd0, c[3:0]};
                end else begin
                    q.push_back('{c: {c[3:0], lo.c[3:0]}, k: {k[3:0], lo.k[3:0]},
                                  d: {d[31:0], lo.d[31:0]}});
                end
            end else begin
                mac_data = d;
                mac_datak = k;
                mac_compl = c;
                q.push_back('{c: c, k: k, d: d});
            end
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(q.size() == 0, tag, "words left undelivered", 64'(q.size()), 64'd0);
    endtask

    initial begin
        do_reset(2'b10);
        run(1'b0, 20, 8'h10, "R2", 1'b0, 1'b0);
        do_reset(2'b00);
        run(1'b0, 10, 8'h40, "R8", 1'b0, 1'b0);
        do_reset(2'b11);
        run(1'b0, 10, 8'h70, "R8", 1'b0, 1'b0);
        do_reset(2'b01);
        run(1'b1, 24, 8'h20, "R3", 1'b0, 1'b0);
        do_reset(2'b01);
        run(1'b1, 16, 8'h90, "R10", 1'b1, 1'b0);
        do_reset(2'b01);
        run(1'b1, 16, 8'hB0, "R9", 1'b0, 1'b1);
        do_reset(2'b10);
        run(1'b0, 8, 8'hC8, "R9", 1'b0, 1'b1);
        // Half-sent pair, then reset: the next word must start a new pair (R7).
        do_reset(2'b01);
        mon_narrow = 1'b1;
        mac_data = 64'hDEAD_BEEF_CAFE_F00D;
        mac_datak = 8'h0F;
        mac_compl = 8'h0A;
        @(negedge clk);
        do_reset(2'b01);
        run(1'b1, 12, 8'hE0, "R7", 1'b0, 1'b0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(10 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule